// File: doc/BRIEF.md
# Charge-Redistribution SAR Controller

This block sequences a binary-weighted capacitor array and one comparator to perform a successive-approximation conversion. The array has weighted capacitors from C down to the unit value, plus one unit-sized termination capacitor, so the total is 2C. Each capacitor has a three-way bottom-plate switch that selects ground, the analog input or the reference. One more switch ties the shared top node to ground. The controller drives all of these switches and reads one comparator decision per bit.

A conversion is started by a one-cycle `start` pulse and runs in four phases. First the top node is grounded while the bottom plates follow the input. Then the top node is released. Then every bottom plate is grounded. Finally one trial is made per bit, from the most significant down. The result is the set of capacitors left on the reference. That set stays applied after the conversion, and the `code` output holds the same set. In bipolar mode, the largest capacitor sits on the reference while the input is stored. This shifts the stored charge by half the reference, so inputs below zero produce codes below midscale.

The comparator settling time per bit, and the input tracking time, are set by a count on a port. That count is captured at start.

Top module: `sar_redist_ctrl`

## Requirements
- R1: After reset, `busy`, `done` and `top_gnd` are 0, `code` is 0, and every bottom-plate field selects ground.
- R2: Each bottom-plate field is 2 bits wide. Capacitor k uses `bot_sel[2k+1:2k]`: k = 0 is the unit capacitor, k = N-1 is the largest, and k = N is the termination capacitor. The encodings are 00 = ground, 01 = input, 10 = reference. An accepted start drives `top_gnd` to 1 for exactly S+1 cycles, where S is the captured settle count. In unipolar mode, all N+1 fields select input during that time.
- R3: The top switch opens one full cycle before any bottom plate moves. The cycle after that, all N+1 fields select ground. No bottom-plate field changes in any cycle whose preceding cycle had `top_gnd` at 1.
- R4: Bits are tried from N-1 down to 0. Each trial puts its capacitor on the reference for S+1 cycles, and the comparator is sampled in the last of those cycles. If `cmp_above` is 1, the bit stays on the reference. If it is 0, the bit returns to ground.
- R5: A conversion makes exactly N trials. `done` rises S+3+N·(S+1) clock edges after the edge that accepted start.
- R6: When `done` is high, bit k of `code` is 1 exactly when field k selects reference. The fields and `code` keep these values until the next accepted start.
- R7: In bipolar mode, field N-1 selects reference rather than input while `top_gnd` is 1 and during the release cycle. The other fields select input.
- R8: `done` is a single-cycle pulse and coincides with `busy` falling. `busy` is 1 from the cycle after an accepted start until that pulse.
- R9: `start` is ignored while `busy` is 1, including in the cycle of the last bit decision. Neither the timing nor the result of the running conversion changes. A `start` held into the `done` cycle is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request a conversion (accepted when idle) |
| bipolar | input | 1 | Offset the stored charge by half the reference (captured at start) |
| settle_cycles | input | SETTLE_W | Extra cycles per sampling and per bit trial (captured at start) |
| cmp_above | input | 1 | Comparator: 1 keeps the bit under trial |
| bot_sel | output | 2*(N+1) | Bottom-plate switch selects, 2 bits per capacitor |
| top_gnd | output | 1 | 1 closes the top-node grounding switch |
| code | output | N | Conversion result |
| busy | output | 1 | Conversion in progress |
| done | output | 1 | One-cycle pulse at the end of a conversion |

## Verification
Two events can fall in the same cycle: a new start request, and the final bit decision or the completion pulse of the running conversion. The bench raises `start` at the final decision edge and holds it for one more edge. It expects the first edge to be ignored: `done` still pulses with `top_gnd` low. It expects the second edge to begin sampling, and the follow-on result must be correct. A behavioural charge model computes the comparator from the switch states actually driven. Sampling-phase selects, release ordering, latency and final codes are then judged against closed-form values.

// File: rtl/sar_cr_pkg.sv
package sar_cr_pkg;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_SAMPLE,
        PH_OPEN,
        PH_HOLD,
        PH_TRIAL
    } phase_e;

    typedef enum logic [1:0] {
        SW_GND = 2'b00,
        SW_VIN = 2'b01,
        SW_REF = 2'b10
    } sw_e;

endpackage

// File: rtl/sar_settle_cnt.sv
module sar_settle_cnt #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         expired
);
    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load) begin
            cnt_d = load_val;
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign expired = (cnt_q == '0);

    // R4: after a load, the count only moves downward until reloaded
    a_r4_count_down: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));

endmodule

// File: rtl/sar_switch_map.sv
module sar_switch_map
    import sar_cr_pkg::*;
#(
    parameter int N = 8
) (
    input  phase_e           phase,
    input  logic             bip,
    input  logic [N-1:0]     bits,
    output logic [2*N+1:0]   sel
);
    for (genvar k = 0; k <= N; k++) begin : g_cap
        sw_e s;
        always_comb begin
            case (phase)
                PH_SAMPLE, PH_OPEN:
                    s = (bip && k == N - 1) ? SW_REF : SW_VIN;
                PH_HOLD:
                    s = SW_GND;
                default:
                    if (k == N) s = SW_GND;
                    else        s = bits[k % N] ? SW_REF : SW_GND;
            endcase
        end
        assign sel[2*k +: 2] = s;
    end

endmodule

// File: rtl/sar_redist_ctrl.sv
module sar_redist_ctrl
    import sar_cr_pkg::*;
#(
    parameter int N        = 8,
    parameter int SETTLE_W = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start,
    input  logic                bipolar,
    input  logic [SETTLE_W-1:0] settle_cycles,
    input  logic                cmp_above,
    output logic [2*N+1:0]      bot_sel,
    output logic                top_gnd,
    output logic [N-1:0]        code,
    output logic                busy,
    output logic                done
);
    localparam int IW = (N > 1) ? $clog2(N) : 1;
    localparam logic [IW-1:0] MSB_IDX = IW'(N - 1);

    typedef struct packed {
        phase_e              phase;
        logic                bip;
        logic [SETTLE_W-1:0] settle;
        logic [IW-1:0]       idx;
        logic [N-1:0]        bits;
        logic [N-1:0]        code;
        logic                done;
    } state_t;

    state_t st_d, st_q;
    logic                load;
    logic [SETTLE_W-1:0] load_val;
    logic                expired;
    logic [N-1:0]        bits_n;

    sar_settle_cnt #(.W(SETTLE_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load),
        .load_val (load_val),
        .expired  (expired)
    );

    sar_switch_map #(.N(N)) u_map (
        .phase (st_q.phase),
        .bip   (st_q.bip),
        .bits  (st_q.bits),
        .sel   (bot_sel)
    );

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        load      = 1'b0;
        load_val  = st_q.settle;
        bits_n    = st_q.bits;
        case (st_q.phase)
            PH_IDLE: begin
                if (start) begin
                    st_d.phase  = PH_SAMPLE;
                    st_d.bip    = bipolar;
                    st_d.settle = settle_cycles;
                    st_d.bits   = '0;
                    load        = 1'b1;
                    load_val    = settle_cycles;
                end
            end
            PH_SAMPLE: begin
                if (expired) st_d.phase = PH_OPEN;
            end
            PH_OPEN: begin
                st_d.phase = PH_HOLD;
            end
            PH_HOLD: begin
                st_d.phase         = PH_TRIAL;
                st_d.idx           = MSB_IDX;
                st_d.bits          = '0;
                st_d.bits[MSB_IDX] = 1'b1;
                load               = 1'b1;
            end
            PH_TRIAL: begin
                if (expired) begin
                    if (!cmp_above) bits_n[st_q.idx] = 1'b0;
                    if (st_q.idx == '0) begin
                        st_d.phase = PH_IDLE;
                        st_d.code  = bits_n;
                        st_d.done  = 1'b1;
                    end else begin
                        bits_n[st_q.idx - 1'b1] = 1'b1;
                        st_d.idx = st_q.idx - 1'b1;
                        load     = 1'b1;
                    end
                    st_d.bits = bits_n;
                end
            end
            default: st_d.phase = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{phase: PH_IDLE, bip: 1'b0, settle: '0, idx: '0,
                      bits: '0, code: '0, done: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign top_gnd = (st_q.phase == PH_SAMPLE);
    assign busy    = (st_q.phase != PH_IDLE);
    assign code    = st_q.code;
    assign done    = st_q.done;

    logic [N-1:0] ref_view;
    always_comb begin
        for (int k = 0; k < N; k++) ref_view[k] = (bot_sel[2*k +: 2] == SW_REF);
    end

    // R2: termination capacitor follows the input while the top node is grounded
    a_r2_term_tracks: assert property (@(posedge clk) disable iff (!rst_n)
        top_gnd |-> (bot_sel[2*N +: 2] == SW_VIN));

    // R3: release of the top node happens while bottom plates hold still
    a_r3_open_first: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(top_gnd) |-> $stable(bot_sel));

    // R3: one cycle after release every plate is grounded
    a_r3_all_ground: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(top_gnd) |=> (bot_sel == '0 && !top_gnd));

    // R6: the reported code matches the switch states
    a_r6_code_is_switches: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (ref_view == code));

    // R8: done lasts a single cycle and coincides with idle
    a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    a_r8_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

endmodule

// File: tb/tb_sar_redist_ctrl.sv
`timescale 1ns/1ps
module tb_sar_redist_ctrl;
    localparam int N  = 8;
    localparam int SW = 4;
    localparam int NV = 11;

    localparam int T_VIN [NV] = '{0, 255, 100, 300, -5, 170, 0, -1, -256, 255, 10};
    localparam int T_BIP [NV] = '{0, 0,   0,   0,   0,  0,   1, 1,  1,    1,   1};
    localparam int T_S   [NV] = '{0, 1,   3,   0,   2,  15,  0, 1,  0,    3,   2};
    localparam int T_EXP [NV] = '{0, 255, 100, 255, 0,  170, 128, 127, 0, 255, 133};

    logic clk = 0;
    logic rst_n = 0;
    logic start = 0;
    logic bipolar = 0;
    logic [SW-1:0] settle_cycles = '0;
    logic cmp_above;
    logic [2*N+1:0] bot_sel;
    logic top_gnd;
    logic [N-1:0] code;
    logic busy;
    logic done;

    int checks = 0;
    int fails = 0;
    int vin = 0;
    int qs = 0;
    int bbm_viol = 0;
    logic prev_top = 0;
    logic [2*N+1:0] prev_sel = '0;
    bit finished = 0;

    always #5 clk = ~clk;

    sar_redist_ctrl #(.N(N), .SETTLE_W(SW)) dut (
        .clk(clk), .rst_n(rst_n), .start(start), .bipolar(bipolar),
        .settle_cycles(settle_cycles), .cmp_above(cmp_above),
        .bot_sel(bot_sel), .top_gnd(top_gnd), .code(code),
        .busy(busy), .done(done)
    );

    // Behavioural array: charge in units of (unit cap x LSB), Vref = 2^N LSB
    function automatic int charge(input logic [2*N+1:0] s, input int v);
        int q = 0;
        for (int k = 0; k <= N; k++) begin
            int w = (k == N) ? 1 : (1 << k);
            if (s[2*k +: 2] == 2'b01) q += w * v;
            else if (s[2*k +: 2] == 2'b10) q += w * (1 << N);
        end
        return q;
    endfunction

    assign cmp_above = ((qs - charge(bot_sel, 0)) >= 0);

    always @(negedge clk) begin
        if (top_gnd) qs = charge(bot_sel, vin);
        if (rst_n && prev_top && bot_sel != prev_sel) bbm_viol++;
        prev_top = top_gnd;
        prev_sel = bot_sel;
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int ref_bits(input logic [2*N+1:0] s);
        int r = 0;
        for (int k = 0; k < N; k++) if (s[2*k +: 2] == 2'b10) r |= (1 << k);
        return r;
    endfunction

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    endtask

    // poke: pulse a start mid-conversion; chain: raise start at the last decision edge
    task automatic run_conv(input int v, input int bip, input int s, input int exp,
                            input bit poke, input bit chain);
        int cycles = 0;
        int samp = 0;
        int klat = s + 3 + N * (s + 1);
        logic [2*N+1:0] want;
        vin = v;
        bipolar = bip[0];
        settle_cycles = SW'(s);
        start = 1;
        @(posedge clk);
        @(negedge clk);
        start = 0;
        want = '0;
        for (int k = 0; k <= N; k++)
            want[2*k +: 2] = (bip != 0 && k == N - 1) ? 2'b10 : 2'b01;
        chk(top_gnd === 1'b1 && busy === 1'b1, "R2 sampling begins, busy", int'(top_gnd), 1);
        chk(bot_sel === want, bip ? "R7 bipolar sample selects" : "R2 sample selects",
            int'(bot_sel), int'(want));
        if (top_gnd) samp++;
        while (done !== 1'b1 && cycles < 2000) begin
            if (poke && cycles == 4) begin
                start = 1; bipolar = 1; settle_cycles = '0;
            end else if (!chain) begin
                start = 0;
            end
            if (chain && cycles == klat - 1) begin
                start = 1; vin = 200; bipolar = 0; settle_cycles = '0;
            end
            @(posedge clk);
            cycles++;
            @(negedge clk);
            if (top_gnd) samp++;
        end
        chk(samp == s + 1, "R2 sampling length", samp, s + 1);
        chk(cycles == klat, "R5 latency", cycles, klat);
        chk(int'(code) == exp, "R4 R6 code", int'(code), exp);
        chk(ref_bits(bot_sel) == exp, "R6 switch states equal code", ref_bits(bot_sel), exp);
        chk(busy === 1'b0, "R8 busy low with done", int'(busy), 0);
        if (chain) chk(top_gnd === 1'b0, "R9 start at last decision ignored", int'(top_gnd), 0);
        @(negedge clk);
        chk(done === 1'b0, "R8 done single cycle", int'(done), 0);
        if (!chain) begin
            chk(ref_bits(bot_sel) == exp && int'(code) == exp, "R6 result held",
                ref_bits(bot_sel), exp);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(busy === 0 && done === 0 && top_gnd === 0, "R1 reset flags", int'(busy), 0);
        chk(code === '0 && bot_sel === '0, "R1 reset code and switches", int'(bot_sel), 0);
        rst_n = 1;
        @(negedge clk);
        chk(busy === 0 && bot_sel === '0, "R1 idle after reset", int'(busy), 0);

        for (int i = 0; i < NV; i++)
            run_conv(T_VIN[i], T_BIP[i], T_S[i], T_EXP[i], 1'b0, 1'b0);

        // R9: start pulsed mid-run with other mode settings changes nothing
        run_conv(77, 0, 1, 77, 1'b1, 1'b0);

        // R9: start held across last decision and done cycle
        run_conv(40, 0, 0, 40, 1'b0, 1'b1);
        chk(top_gnd === 1'b1 && busy === 1'b1, "R9 start in done cycle accepted",
            int'(top_gnd), 1);
        start = 0;
        for (int c = 0; c < 200 && done !== 1'b1; c++) @(negedge clk);
        chk(int'(code) == 200, "R4 chained result", int'(code), 200);

        chk(bbm_viol == 0, "R3 break-before-make", bbm_viol, 0);
        finish_run();
    end

endmodule